// File: doc/BRIEF.md
# Multiplexed Pixel Port Demultiplexer

This block sits at the front of a video output path. It takes one wide pixel word, which holds four lanes (A to D) of colour and palette-select bits, when a load strobe rises. It then plays that word out as a serial stream of one pixel per pixel clock. The sequence is lane A first, so A is the earliest pixel on screen. The word-level video controls (blank, sync, tri-level sync and field) are latched on the same strobe edge and travel with every pixel of that word.

The block also produces its own load strobe. This strobe is the pixel clock divided by the active multiplex ratio, and upstream logic uses it to pace its writes. Three ratios are offered: 2:1, 4:1 and 8:1. The 8:1 ratio packs eight 8-bit palette indices into one word, so it is legal only with the 8-bit pseudo-colour format. Any illegal request raises an error flag and the block runs at 4:1. A strobe edge that arrives before the current word has been fully emitted is dropped, and the block reports an overrun.

Top module: `pixel_port_demux`

## Requirements
- R1: `loadout` has a period of M pixel clocks, where M is the active ratio. It is high for the first M/2 cycles of each period. Reset holds the divider at its start, so `loadout` is 1 during reset and in the first cycle after it.
- R2: `mode_sel` encoding: 0 selects 2:1, 1 selects 4:1, 2 selects 8:1, and 3 is reserved.
- R3: 8:1 is valid only when `fmt_sel` is 3 (8-bit pseudo colour). The other `fmt_sel` codes are 0 (24-bit), 1 (16-bit) and 2 (15-bit). For 8:1 with any other format, and for `mode_sel` 3, `mode_err` is 1 in the same cycle and the block runs at 4:1.
- R4: A word is captured on a pixel-clock edge where `loadin` is 1 and was 0 at the previous edge. Holding `loadin` high captures nothing further.
- R5: In 2:1 and 4:1, pixel k is lane k, with all 24 bits of `pix_rgb` taken from the lane. Lane k occupies `lane_rgb[24k+23:24k]`, with red in bits 23:16, green in 15:8 and blue in 7:0. 2:1 uses lanes A and B only.
- R6: In 8:1, pixel k takes its byte from lane k/2: the red byte when k is even, the green byte when k is odd. The byte appears in `pix_rgb[7:0]` and the upper 16 bits are zero. Its select is lane k/2's select.
- R7: Each pixel carries the select of its lane, taken from `lane_sel[2k+1:2k]` for lane k. Every pixel of a word carries the `blank_in`, `sync_in`, `trisync_in` and `field_in` values latched with that word.
- R8: The first pixel is valid in the cycle after the capture edge, and each following cycle emits the next pixel. After exactly M pixels `pix_valid` drops, unless a capture lands on the edge that ends the last pixel, in which case the next word follows with no gap. The ratio is fixed at capture.
- R9: A rising `loadin` while a word is still playing out and not on its last pixel is ignored. `overrun` is 1 for the one cycle that follows that edge, and the current word finishes unchanged.
- R10: Reset clears the sequencer. `pix_valid` and `overrun` stay 0 from reset until the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| loadin | input | 1 | Load strobe; rising edge captures a word |
| mode_sel | input | 2 | Requested multiplex ratio |
| fmt_sel | input | 2 | Pixel format |
| lane_rgb | input | 96 | Colour bits of lanes A..D |
| lane_sel | input | 8 | Palette-select bits of lanes A..D |
| blank_in | input | 1 | Blank control for the word |
| sync_in | input | 1 | Sync control for the word |
| trisync_in | input | 1 | Tri-level sync control for the word |
| field_in | input | 1 | Odd/even field indicator |
| loadout | output | 1 | Divided load strobe |
| mode_err | output | 1 | Unsupported ratio/format request |
| overrun | output | 1 | Early load strobe dropped |
| pix_valid | output | 1 | Pixel output valid |
| pix_rgb | output | 24 | Pixel colour or palette index |
| pix_sel | output | 2 | Pixel palette select |
| pix_blank | output | 1 | Blank for this pixel |
| pix_sync | output | 1 | Sync for this pixel |
| pix_trisync | output | 1 | Tri-level sync for this pixel |
| pix_field | output | 1 | Field for this pixel |

## Verification
The assertions check four things on every cycle:
- the divider returns to its start after the last count;
- the pixel index steps by one while a word plays out, and the latched controls stay put;
- an overrun leaves the current word running;
- the illegal-request flag always comes with the 4:1 fallback.

Some behaviour only the bench scenarios can show:
- the lane ordering and byte picking in each ratio;
- the exact loadout period;
- gapless back-to-back words;
- an early strobe's data really vanishing from the stream;
- a held-high strobe producing exactly one word.

// File: rtl/pxdemux_pkg.sv
package pxdemux_pkg;
    localparam int COLOR_W   = 8;
    localparam int SEL_W     = 2;
    localparam int LANES     = 4;
    localparam int MAX_RATIO = 8;
    localparam int CNT_W     = $clog2(MAX_RATIO);
    localparam int RATIO_W   = CNT_W + 1;
    localparam int LANE_IX_W = $clog2(LANES);
    localparam int RGB_W     = 3 * COLOR_W;

    typedef enum logic [1:0] {
        MUX_2 = 2'd0, MUX_4 = 2'd1, MUX_8 = 2'd2, MUX_RSVD = 2'd3
    } mux_sel_e;

    typedef enum logic [1:0] {
        FMT_RGB24 = 2'd0, FMT_RGB16 = 2'd1, FMT_RGB15 = 2'd2, FMT_PAL8 = 2'd3
    } pix_fmt_e;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
    } lane_t;

    typedef struct packed {
        logic blank;
        logic sync;
        logic trisync;
        logic field;
    } vctl_t;

    function automatic logic [RATIO_W-1:0] ratio_of(mux_sel_e m, pix_fmt_e f);
        case (m)
            MUX_2:   return RATIO_W'(2);
            MUX_8:   return (f == FMT_PAL8) ? RATIO_W'(MAX_RATIO) : RATIO_W'(4);
            default: return RATIO_W'(4);
        endcase
    endfunction
endpackage

// File: rtl/pxd_mode_check.sv
module pxd_mode_check
    import pxdemux_pkg::*;
(
    input  mux_sel_e           mode_i,
    input  pix_fmt_e           fmt_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               err_o
);
    always_comb begin
        ratio_o = ratio_of(mode_i, fmt_i);
        err_o   = (mode_i == MUX_RSVD) || (mode_i == MUX_8 && fmt_i != FMT_PAL8);
    end
endmodule

// File: rtl/pxd_loadgen.sv
module pxd_loadgen
    import pxdemux_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               loadout_o
);
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   lim;
    logic [RATIO_W-1:0] half;

    assign lim       = CNT_W'(ratio_i - RATIO_W'(1));
    assign half      = ratio_i >> 1;
    assign loadout_o = ({1'b0, cnt_q} < half);

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (cnt_q >= lim) cnt_q <= '0;
        else                   cnt_q <= cnt_q + CNT_W'(1);
    end

    // R1: divider wraps after its last count
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= lim) |=> (cnt_q == '0));
endmodule

// File: rtl/pxd_sequencer.sv
module pxd_sequencer
    import pxdemux_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               loadin_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  lane_t              lanes_i [LANES],
    input  vctl_t              ctl_i,
    output logic               valid_o,
    output logic               ovr_o,
    output logic [RGB_W-1:0]   rgb_o,
    output logic [SEL_W-1:0]   sel_o,
    output vctl_t              ctl_o
);
    logic               ld_q;
    logic               valid_q;
    logic               ovr_q;
    logic [CNT_W-1:0]   idx_q;
    logic [RATIO_W-1:0] m_q;
    lane_t              word_q [LANES];
    vctl_t              ctl_q;
    logic               rise, last, accept;
    logic [LANE_IX_W-1:0] lane_ix;
    lane_t              cur;

    assign rise   = loadin_i && !ld_q;
    assign last   = (idx_q == CNT_W'(m_q - RATIO_W'(1)));
    assign accept = rise && (!valid_q || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_q    <= 1'b0;
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
            idx_q   <= '0;
            m_q     <= RATIO_W'(4);
            ctl_q   <= '0;
        end else begin
            ld_q  <= loadin_i;
            ovr_q <= rise && valid_q && !last;
            if (accept) begin
                valid_q <= 1'b1;
                idx_q   <= '0;
                m_q     <= ratio_i;
                ctl_q   <= ctl_i;
            end else if (valid_q) begin
                if (last) valid_q <= 1'b0;
                else      idx_q   <= idx_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (accept) word_q <= lanes_i;
    end

    always_comb begin
        if (m_q == RATIO_W'(MAX_RATIO)) lane_ix = idx_q[CNT_W-1:1];
        else                            lane_ix = idx_q[LANE_IX_W-1:0];
        cur = word_q[lane_ix];
        if (m_q == RATIO_W'(MAX_RATIO))
            rgb_o = {{(RGB_W-COLOR_W){1'b0}}, (idx_q[0] ? cur.g : cur.r)};
        else
            rgb_o = {cur.r, cur.g, cur.b};
        sel_o = cur.sel;
    end

    assign valid_o = valid_q;
    assign ovr_o   = ovr_q;
    assign ctl_o   = ctl_q;

    // R8: index advances one pixel per clock mid-word
    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !last && !rise) |=> (valid_q && idx_q == $past(idx_q) + CNT_W'(1)));
    // R7: latched controls hold for the whole word
    p_ctl_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !last) |=> $stable(ctl_q));
    // R9: a dropped strobe never cuts the running word
    p_overrun_busy_r9: assert property (@(posedge clk) disable iff (rst)
        ovr_q |-> valid_q);
    // R10: reset leaves the output idle
    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (!valid_q && !ovr_q));
endmodule

// File: rtl/pixel_port_demux.sv
module pixel_port_demux
    import pxdemux_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     loadin,
    input  logic [1:0]               mode_sel,
    input  logic [1:0]               fmt_sel,
    input  logic [LANES*RGB_W-1:0]   lane_rgb,
    input  logic [LANES*SEL_W-1:0]   lane_sel,
    input  logic                     blank_in,
    input  logic                     sync_in,
    input  logic                     trisync_in,
    input  logic                     field_in,
    output logic                     loadout,
    output logic                     mode_err,
    output logic                     overrun,
    output logic                     pix_valid,
    output logic [RGB_W-1:0]         pix_rgb,
    output logic [SEL_W-1:0]         pix_sel,
    output logic                     pix_blank,
    output logic                     pix_sync,
    output logic                     pix_trisync,
    output logic                     pix_field
);
    logic [RATIO_W-1:0] eff_ratio;
    lane_t              lanes [LANES];
    vctl_t              ctl_in, ctl_out;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lanes[i].r   = lane_rgb[i*RGB_W + 2*COLOR_W +: COLOR_W];
        assign lanes[i].g   = lane_rgb[i*RGB_W + COLOR_W   +: COLOR_W];
        assign lanes[i].b   = lane_rgb[i*RGB_W             +: COLOR_W];
        assign lanes[i].sel = lane_sel[i*SEL_W +: SEL_W];
    end

    assign ctl_in = '{blank: blank_in, sync: sync_in, trisync: trisync_in, field: field_in};

    pxd_mode_check u_mode (
        .mode_i  (mux_sel_e'(mode_sel)),
        .fmt_i   (pix_fmt_e'(fmt_sel)),
        .ratio_o (eff_ratio),
        .err_o   (mode_err)
    );

    pxd_loadgen u_load (
        .clk       (clk),
        .rst       (rst),
        .ratio_i   (eff_ratio),
        .loadout_o (loadout)
    );

    pxd_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .loadin_i (loadin),
        .ratio_i  (eff_ratio),
        .lanes_i  (lanes),
        .ctl_i    (ctl_in),
        .valid_o  (pix_valid),
        .ovr_o    (overrun),
        .rgb_o    (pix_rgb),
        .sel_o    (pix_sel),
        .ctl_o    (ctl_out)
    );

    assign pix_blank   = ctl_out.blank;
    assign pix_sync    = ctl_out.sync;
    assign pix_trisync = ctl_out.trisync;
    assign pix_field   = ctl_out.field;

    // R3: an illegal request always runs at 4:1
    p_fallback_r3: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> (eff_ratio == RATIO_W'(4)));
endmodule

// File: tb/pixel_port_demux_test.sv
module pixel_port_demux_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        loadin = 1'b0;
    logic [1:0]  mode_sel = 2'd1, fmt_sel = 2'd0;
    logic [95:0] lane_rgb = '0;
    logic [7:0]  lane_sel = '0;
    logic        blank_in = 0, sync_in = 0, trisync_in = 0, field_in = 0;
    logic        loadout, mode_err, overrun, pix_valid;
    logic [23:0] pix_rgb;
    logic [1:0]  pix_sel;
    logic        pix_blank, pix_sync, pix_trisync, pix_field;

    int checks = 0, failures = 0;
    logic [29:0] exp_q [$];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_port_demux uut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ratio(input logic [1:0] m, input logic [1:0] f);
        if (m == 2'd0) return 2;
        if (m == 2'd2 && f == 2'd3) return 8;
        return 4;
    endfunction

    // expected pixel: {blank,sync,trisync,field, sel[1:0], rgb[23:0]}
    function automatic logic [29:0] exp_pix(input int m, input int k, input logic [95:0] rgb,
                                            input logic [7:0] sel, input logic [3:0] ctl);
        int ln;
        logic [23:0] c;
        ln = (m == 8) ? k / 2 : k;
        if (m == 8) c = {16'h0, (k % 2 == 0) ? rgb[ln*24+16 +: 8] : rgb[ln*24+8 +: 8]};
        else        c = rgb[ln*24 +: 24];
        return {ctl, sel[ln*2 +: 2], c};
    endfunction

    // driver: enters at posedge+1, leaves M cycles later at posedge+1
    task automatic send_word(input logic [1:0] m, input logic [1:0] f, input logic [95:0] rgb,
                             input logic [7:0] sel, input logic [3:0] ctl);
        int n;
        n = ratio(m, f);
        for (int k = 0; k < n; k++) exp_q.push_back(exp_pix(n, k, rgb, sel, ctl));
        mode_sel = m; fmt_sel = f; lane_rgb = rgb; lane_sel = sel;
        {blank_in, sync_in, trisync_in, field_in} = ctl;
        loadin = 1'b1;
        @(posedge clk); #1;
        loadin = 1'b0;
        repeat (n - 1) begin @(posedge clk); #1; end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic measure_period(input int m, input string req);
        logic prev;
        int n;
        prev = loadout;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!prev && loadout) break;
            prev = loadout;
        end
        n = 0;
        prev = loadout;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            n++;
            if (!prev && loadout) break;
            prev = loadout;
        end
        check(n == m, req, n, m);
    endtask

    // monitor: scoreboard compare
    always @(negedge clk) begin
        if (!rst && pix_valid) begin
            if (exp_q.size() == 0)
                check(0, "R8 unexpected pixel", {2'b0, pix_blank, pix_sync, pix_trisync, pix_field, pix_sel, pix_rgb}, 0);
            else begin
                logic [29:0] e;
                logic [29:0] a;
                e = exp_q.pop_front();
                a = {pix_blank, pix_sync, pix_trisync, pix_field, pix_sel, pix_rgb};
                check(a == e, "R5/R6/R7 pixel", {2'b0, a}, {2'b0, e});
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R10 / R1: reset state
        repeat (3) @(negedge clk);
        check(pix_valid == 0, "R10 valid in reset", pix_valid, 0);
        check(loadout == 1, "R1 loadout in reset", loadout, 1);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(loadout == 1, "R1 loadout after reset", loadout, 1);
        check(pix_valid == 0 && overrun == 0, "R10 idle after reset", {pix_valid, overrun}, 0);
        idle(3);
        check(pix_valid == 0, "R10 idle until capture", pix_valid, 0);

        // R2 / R1: loadout periods
        mode_sel = 2'd0; fmt_sel = 2'd0; measure_period(2, "R1 R2 period 2:1");
        mode_sel = 2'd1;                 measure_period(4, "R1 R2 period 4:1");
        mode_sel = 2'd2; fmt_sel = 2'd3; measure_period(8, "R1 R2 period 8:1");
        @(negedge clk);
        check(mode_err == 0, "R3 legal 8:1", mode_err, 0);
        // R3: illegal requests
        fmt_sel = 2'd0; #1;
        check(mode_err == 1, "R3 8:1 true colour flagged", mode_err, 1);
        measure_period(4, "R3 fallback period");
        mode_sel = 2'd3; #1;
        check(mode_err == 1, "R3 reserved flagged", mode_err, 1);
        fmt_sel = 2'd3; #1;
        check(mode_err == 1, "R3 reserved flagged pal8", mode_err, 1);
        @(posedge clk); #1;

        // R5, R7: 4:1 and 2:1 words, back to back (R8 gapless)
        send_word(2'd1, 2'd0, 96'h0C0B0A_090807_060504_030201, 8'b11_10_01_00, 4'b1010);
        send_word(2'd1, 2'd1, 96'hFFEEDD_CCBBAA_998877_665544, 8'b00_01_10_11, 4'b0101);
        send_word(2'd0, 2'd2, 96'h111111_222222_A5A5A5_5A5A5A, 8'b00_00_10_01, 4'b1111);
        idle(4);
        check(pix_valid == 0, "R8 valid drops after M", pix_valid, 0);

        // R6: 8:1 pseudo colour
        send_word(2'd2, 2'd3, 96'h807F00_605F00_403F00_201F00, 8'b01_10_11_00, 4'b0011);
        send_word(2'd2, 2'd3, 96'hF1F200_E1E200_D1D200_C1C200, 8'b10_11_00_01, 4'b1100);
        idle(2);
        // R3: 8:1 with true colour runs as 4:1 sequence
        send_word(2'd2, 2'd0, 96'hABCDEF_123456_789ABC_DEF012, 8'b11_11_00_00, 4'b0001);
        idle(3);

        // R9: early strobe is dropped
        send_word(2'd2, 2'd3, 96'h0D0C00_0B0A00_090800_070600, 8'b00_01_10_11, 4'b0110);
        // send_word returned at end of this word; replay manual early strobe case
        idle(2);
        begin
            for (int k = 0; k < 8; k++) exp_q.push_back(exp_pix(8, k, 96'h44_33_00_22_11_00_66_55_00_88_77_00, 8'hE4, 4'b1001));
            mode_sel = 2'd2; fmt_sel = 2'd3;
            lane_rgb = 96'h44_33_00_22_11_00_66_55_00_88_77_00; lane_sel = 8'hE4;
            {blank_in, sync_in, trisync_in, field_in} = 4'b1001;
            loadin = 1;
            @(posedge clk); #1 loadin = 0;
            lane_rgb = '1; lane_sel = '0; {blank_in, sync_in, trisync_in, field_in} = 4'b0000;
            @(posedge clk); #1;
            @(posedge clk); #1 loadin = 1;
            @(posedge clk);
            @(negedge clk);
            check(overrun == 1, "R9 overrun pulse", overrun, 1);
            loadin = 0;
            @(negedge clk);
            check(overrun == 0, "R9 overrun one cycle", overrun, 0);
            idle(8);
        end

        // R4: held-high strobe yields one word
        begin
            int vcnt;
            for (int k = 0; k < 4; k++) exp_q.push_back(exp_pix(4, k, 96'h1, 8'h0, 4'b0));
            mode_sel = 2'd1; fmt_sel = 2'd0; lane_rgb = 96'h1; lane_sel = 0;
            {blank_in, sync_in, trisync_in, field_in} = 4'b0;
            loadin = 1;
            vcnt = 0;
            repeat (12) begin @(negedge clk); if (pix_valid) vcnt++; end
            loadin = 0;
            check(vcnt == 4, "R4 held strobe single word", vcnt, 4);
            idle(3);
        end

        check(exp_q.size() == 0, "R8 all pixels emitted", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule